// File: doc/BRIEF.md
# DMA Channel Enable and State Controller

This block holds the control state of a single DMA channel. Software programs it through a small indexed register port. The port reaches a control word, a transfer count, a peripheral address and a memory address, plus a status word and a write-one-to-clear flag register. Once the channel is enabled, the block issues single-transfer start pulses toward a bus master. It presents the current peripheral and memory addresses with each pulse. It then waits for that master to acknowledge the transfer, with or without a bus error.

After each good transfer the block decrements the working count and steps each address whose increment option is set. When the count runs out, it raises a done flag. In circular mode it also reloads the count and both addresses from the values software last programmed, and it keeps running. A bus error raises an error flag and drops the enable in the same clock edge. Software cannot enable the channel again until it has cleared that flag. While the channel is enabled, every configuration field is frozen. The block refuses to enable a channel whose control word asks for circular and memory-to-memory operation together.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0: control, count, both addresses and status. `chan_active`, `done_flag`, `err_flag` and `xfer_start` are 0.
- R2: The register map and encoding are as follows. Index 0 is control: bit0 enable, bit1 circular, bit2 memory-to-memory, bit3 peripheral-address increment, bit4 memory-address increment, bit5 direction (1 = memory to peripheral). Index 1 is count, index 2 the peripheral address and index 3 the memory address. Index 4 is status: bit0 done, bit1 error. Index 5 is flag clear. Read data appears one clock after `reg_ridx` is presented.
- R3: In a mode other than memory-to-memory, each single-cycle `dma_req` pulse on an enabled channel with a nonzero count produces exactly one `xfer_start` pulse, one clock wide.
- R4: On each acknowledged transfer without error, the count drops by 1. Each address advances by 1 only if its increment bit is set; otherwise it holds. `xfer_paddr` and `xfer_maddr` show the addresses of the transfer being started.
- R5: When the count reaches 0 the done flag is set. In normal mode no further transfers are started, and the enable bit stays 1.
- R6: In circular mode, when the count reaches 0 the count and both addresses reload from their programmed values and the channel stays enabled and keeps serving requests.
- R7: In memory-to-memory mode, transfers are started back to back without any `dma_req` until the count reaches 0.
- R8: A transfer acknowledged with `xfer_err` high sets the error flag and clears the enable bit on the same clock edge.
- R9: While the error flag is 1, a write of 1 to the enable bit is ignored. After the flag is cleared, the same write enables the channel.
- R10: While the enable bit is 1, a control write changes only the enable bit, and writes to the count and address registers are ignored.
- R11: A control write with both circular and memory-to-memory bits set leaves the channel disabled.
- R12: Writing 0 to the enable bit of an active channel aborts it: no further transfer starts.
- R13: Writing 1 to flag-clear bit0 or bit1 clears the done or error flag. Writing 0 to a bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_widx | input | 3 | Register index for write |
| reg_wdata | input | 32 | Write data |
| reg_ridx | input | 3 | Register index for read |
| reg_rdata | output | 32 | Registered read data |
| dma_req | input | 1 | Peripheral transfer request pulse |
| xfer_start | output | 1 | One-cycle pulse starting a single transfer |
| xfer_paddr | output | 16 | Peripheral address of the current transfer |
| xfer_maddr | output | 16 | Memory address of the current transfer |
| xfer_to_periph | output | 1 | Direction: 1 = memory to peripheral |
| xfer_ack | input | 1 | Bus master reports the transfer finished |
| xfer_err | input | 1 | Bus error, valid with `xfer_ack` |
| chan_active | output | 1 | Enable bit state |
| done_flag | output | 1 | Transfer-complete flag |
| err_flag | output | 1 | Transfer-error flag |

## Verification
The assertions assume that the bus master raises `xfer_ack` only while a transfer it was started on is outstanding. They also assume `xfer_err` is meaningful only together with `xfer_ack`. They further assume that software does not disable the channel while a transfer is in flight on the bus. The stimulus respects all of this. Each acknowledge is a single cycle placed right after a visible `xfer_start`. Error is never raised on its own. Every abort or reconfiguration happens only after the last acknowledge has been given.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] RI_CTRL   = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_COUNT  = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_PADDR  = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_MADDR  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_STATUS = 3'd4;
  localparam logic [REG_IDX_W-1:0] RI_FCLR   = 3'd5;

  localparam int CB_EN   = 0;
  localparam int CB_CIRC = 1;
  localparam int CB_M2M  = 2;
  localparam int CB_PINC = 3;
  localparam int CB_MINC = 4;
  localparam int CB_DIR  = 5;

  localparam int NUM_FLAGS = 2;
  localparam int FL_DONE   = 0;
  localparam int FL_ERR    = 1;

  localparam int NUM_PTRS = 2;
  localparam int PT_PERIPH = 0;
  localparam int PT_MEM    = 1;

  typedef enum logic {SQ_IDLE, SQ_WAIT} seq_state_t;

  // control fields above the enable bit, in register bit order (MSB first)
  typedef struct packed {
    logic dir;
    logic minc;
    logic pinc;
    logic m2m;
    logic circ;
  } chan_cfg_t;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 te_set,
  input  logic                 te_flag,
  output logic                 en,
  output chan_cfg_t            cfg,
  output logic [CW-1:0]        cnt_shadow,
  output logic [AW-1:0]        pa_shadow,
  output logic [AW-1:0]        ma_shadow,
  output logic                 ld_cnt,
  output logic                 ld_pa,
  output logic                 ld_ma
);
  logic wr_ctrl;
  logic bad_combo;

  assign wr_ctrl   = wr_en && (wr_idx == RI_CTRL);
  assign bad_combo = wr_data[CB_CIRC] && wr_data[CB_M2M];

  // programming of count/addresses is accepted only on an idle channel
  assign ld_cnt = wr_en && (wr_idx == RI_COUNT) && !en;
  assign ld_pa  = wr_en && (wr_idx == RI_PADDR) && !en;
  assign ld_ma  = wr_en && (wr_idx == RI_MADDR) && !en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      cfg        <= '0;
      cnt_shadow <= '0;
      pa_shadow  <= '0;
      ma_shadow  <= '0;
    end else begin
      if (wr_ctrl && !en) begin
        cfg <= chan_cfg_t'(wr_data[CB_DIR:CB_CIRC]);
      end
      if (te_set) begin
        en <= 1'b0;
      end else if (wr_ctrl) begin
        if (en) begin
          en <= wr_data[CB_EN];
        end else begin
          en <= wr_data[CB_EN] && !te_flag && !bad_combo;
        end
      end
      if (ld_cnt) cnt_shadow <= wr_data[CW-1:0];
      if (ld_pa)  pa_shadow  <= wr_data[AW-1:0];
      if (ld_ma)  ma_shadow  <= wr_data[AW-1:0];
    end
  end
endmodule

// File: rtl/dma_flag_bits.sv
module dma_flag_bits #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (set_vec[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_wr && clr_mask[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          inc_en,
  input  logic          reload,
  input  logic [AW-1:0] reload_val,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld) begin
      ptr <= ld_val;
    end else if (reload) begin
      ptr <= reload_val;
    end else if (step && inc_en) begin
      ptr <= ptr + AW'(1);
    end
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          m2m,
  input  logic          circ,
  input  logic          preq,
  input  logic          ack,
  input  logic          err,
  input  logic          ld_cnt,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] cnt_shadow,
  output logic          xfer_start,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          beat_ok,
  output logic          wrap,
  output logic          tc_set,
  output logic          te_set
);
  seq_state_t state;
  logic       pend;
  logic       issue;
  logic       last;

  assign busy    = (state == SQ_WAIT);
  assign issue   = (state == SQ_IDLE) && en && (cnt != '0) && (m2m || pend);
  assign beat_ok = busy && en && ack && !err;
  assign te_set  = busy && en && ack && err;
  assign last    = beat_ok && (cnt == CW'(1));
  assign tc_set  = last;
  assign wrap    = last && circ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      pend       <= 1'b0;
      xfer_start <= 1'b0;
      cnt        <= '0;
    end else begin
      xfer_start <= issue;
      if (!en) begin
        pend <= 1'b0;
      end else begin
        pend <= (pend && !issue) || (preq && !m2m);
      end
      case (state)
        SQ_IDLE: if (issue) state <= SQ_WAIT;
        SQ_WAIT: if (!en || ack) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
      if (ld_cnt) begin
        cnt <= ld_val;
      end else if (wrap) begin
        cnt <= cnt_shadow;
      end else if (beat_ok) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_widx,
  input  logic [DW-1:0]        reg_wdata,
  input  logic [REG_IDX_W-1:0] reg_ridx,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 dma_req,
  output logic                 xfer_start,
  output logic [AW-1:0]        xfer_paddr,
  output logic [AW-1:0]        xfer_maddr,
  output logic                 xfer_to_periph,
  input  logic                 xfer_ack,
  input  logic                 xfer_err,
  output logic                 chan_active,
  output logic                 done_flag,
  output logic                 err_flag
);
  localparam int CTRL_W = CB_DIR + 1;

  chan_cfg_t       cfg_q;
  logic            en_q;
  logic [CW-1:0]   cnt_shadow, cnt_q;
  logic [AW-1:0]   pa_shadow, ma_shadow;
  logic            ld_cnt, ld_pa, ld_ma;
  logic            seq_busy, beat_ok, wrap, tc_set, te_set;
  logic [NUM_FLAGS-1:0] flag_q, flag_set;
  logic            fclr_wr;
  logic [NUM_PTRS-1:0]  ptr_ld, ptr_inc;
  logic [AW-1:0]   ptr_ldval [NUM_PTRS];
  logic [AW-1:0]   ptr_rlval [NUM_PTRS];
  logic [AW-1:0]   ptr_q     [NUM_PTRS];
  logic [DW-1:0]   rd_mux;

  dma_cfg_regs #(.DW(DW), .CW(CW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .wr_idx(reg_widx), .wr_data(reg_wdata),
    .te_set(te_set), .te_flag(flag_q[FL_ERR]),
    .en(en_q), .cfg(cfg_q),
    .cnt_shadow(cnt_shadow), .pa_shadow(pa_shadow), .ma_shadow(ma_shadow),
    .ld_cnt(ld_cnt), .ld_pa(ld_pa), .ld_ma(ld_ma)
  );

  dma_xfer_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst),
    .en(en_q), .m2m(cfg_q.m2m), .circ(cfg_q.circ),
    .preq(dma_req), .ack(xfer_ack), .err(xfer_err),
    .ld_cnt(ld_cnt), .ld_val(reg_wdata[CW-1:0]), .cnt_shadow(cnt_shadow),
    .xfer_start(xfer_start), .busy(seq_busy), .cnt(cnt_q),
    .beat_ok(beat_ok), .wrap(wrap), .tc_set(tc_set), .te_set(te_set)
  );

  assign ptr_ld[PT_PERIPH]    = ld_pa;
  assign ptr_ld[PT_MEM]       = ld_ma;
  assign ptr_inc[PT_PERIPH]   = cfg_q.pinc;
  assign ptr_inc[PT_MEM]      = cfg_q.minc;
  assign ptr_ldval[PT_PERIPH] = reg_wdata[AW-1:0];
  assign ptr_ldval[PT_MEM]    = reg_wdata[AW-1:0];
  assign ptr_rlval[PT_PERIPH] = pa_shadow;
  assign ptr_rlval[PT_MEM]    = ma_shadow;

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    dma_addr_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst(rst),
      .ld(ptr_ld[p]), .ld_val(ptr_ldval[p]),
      .step(beat_ok), .inc_en(ptr_inc[p]),
      .reload(wrap), .reload_val(ptr_rlval[p]),
      .ptr(ptr_q[p])
    );
  end

  assign fclr_wr            = reg_wr && (reg_widx == RI_FCLR);
  assign flag_set[FL_DONE]  = tc_set;
  assign flag_set[FL_ERR]   = te_set;

  dma_flag_bits #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst),
    .set_vec(flag_set), .clr_wr(fclr_wr),
    .clr_mask(reg_wdata[NUM_FLAGS-1:0]),
    .flags(flag_q)
  );

  assign xfer_paddr     = ptr_q[PT_PERIPH];
  assign xfer_maddr     = ptr_q[PT_MEM];
  assign xfer_to_periph = cfg_q.dir;
  assign chan_active    = en_q;
  assign done_flag      = flag_q[FL_DONE];
  assign err_flag       = flag_q[FL_ERR];

  always_comb begin
    rd_mux = '0;
    case (reg_ridx)
      RI_CTRL:   rd_mux[CTRL_W-1:0]    = {cfg_q, en_q};
      RI_COUNT:  rd_mux[CW-1:0]        = cnt_q;
      RI_PADDR:  rd_mux[AW-1:0]        = ptr_q[PT_PERIPH];
      RI_MADDR:  rd_mux[AW-1:0]        = ptr_q[PT_MEM];
      RI_STATUS: rd_mux[NUM_FLAGS-1:0] = flag_q;
      default:   rd_mux                = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       chan_active,
  input logic       err_flag,
  input logic       xfer_start,
  input logic       xfer_ack,
  input logic       xfer_err,
  input logic       seq_busy,
  input logic [4:0] cfg_bits
);
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  a_r8_err_drops_enable: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && chan_active && xfer_ack && xfer_err) |=> (!chan_active && err_flag));

  a_r9_interlock: assert property (@(posedge clk) disable iff (rst)
    (!chan_active && err_flag) |=> !chan_active);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    chan_active |=> $stable(cfg_bits));

  a_r11_no_circ_m2m: assert property (@(posedge clk) disable iff (rst)
    chan_active |-> !(cfg_bits[0] && cfg_bits[1]));

  a_r12_abort_idles: assert property (@(posedge clk) disable iff (rst)
    !chan_active |=> !seq_busy);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (
  .clk(clk), .rst(rst),
  .chan_active(chan_active), .err_flag(err_flag),
  .xfer_start(xfer_start), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
  .seq_busy(seq_busy), .cfg_bits(cfg_q)
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [2:0]  reg_widx;
  logic [31:0] reg_wdata;
  logic [2:0]  reg_ridx;
  logic [31:0] reg_rdata;
  logic        dma_req;
  logic        xfer_start;
  logic [15:0] xfer_paddr, xfer_maddr;
  logic        xfer_to_periph;
  logic        xfer_ack, xfer_err;
  logic        chan_active, done_flag, err_flag;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl u0 (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_widx(reg_widx), .reg_wdata(reg_wdata),
    .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
    .dma_req(dma_req), .xfer_start(xfer_start),
    .xfer_paddr(xfer_paddr), .xfer_maddr(xfer_maddr),
    .xfer_to_periph(xfer_to_periph),
    .xfer_ack(xfer_ack), .xfer_err(xfer_err),
    .chan_active(chan_active), .done_flag(done_flag), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_widx = 3'(idx); reg_wdata = 32'(data);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output int v);
    @(negedge clk);
    reg_ridx = 3'(idx);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    dma_req = 1'b1;
    @(negedge clk);
    dma_req = 1'b0;
  endtask

  task automatic serve(input bit err, output bit got, output int pa, output int ma);
    got = 1'b0; pa = -1; ma = -1;
    for (int k = 0; k < 30 && !got; k++) begin
      @(negedge clk);
      if (xfer_start) begin
        got = 1'b1;
        pa = int'(xfer_paddr);
        ma = int'(xfer_maddr);
        xfer_ack = 1'b1; xfer_err = err;
        @(negedge clk);
        xfer_ack = 1'b0; xfer_err = 1'b0;
      end
    end
  endtask

  task automatic no_start(input string tag, input int ncyc);
    int seen = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (xfer_start) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 start", int'(xfer_start), 0);
    chk("R1 active", int'(chan_active), 0);
    chk("R1 flags", int'({err_flag, done_flag}), 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    rd(4, v); chk("R1 status", v, 0);
  endtask

  task automatic t_periph_normal();
    int v, pa, ma; bit got;
    wr(1, 3); wr(2, 'h100); wr(3, 'h200);
    wr(0, 'h31);  // enable, mem increment, memory->peripheral
    chk("R2 direction", int'(xfer_to_periph), 1);
    for (int i = 0; i < 3; i++) begin
      pulse_req();
      serve(1'b0, got, pa, ma);
      chk("R3 one start per request", int'(got), 1);
      chk("R4 periph addr holds", pa, 'h100);
      chk("R4 mem addr steps", ma, 'h200 + i);
      no_start("R3 no extra start", 4);
    end
    rd(1, v); chk("R4 count at end", v, 0);
    rd(4, v); chk("R5 done flag", v, 1);
    pulse_req();
    no_start("R5 stopped at zero", 6);
    rd(0, v); chk("R5 enable kept", v, 'h31);
    wr(5, 0);
    rd(4, v); chk("R13 write 0 keeps flag", v, 1);
    wr(5, 1);
    rd(4, v); chk("R13 clear done", v, 0);
    wr(0, 0);
  endtask

  task automatic t_circular();
    int v, pa, ma; bit got;
    wr(0, 0);
    wr(1, 2); wr(2, 'h40); wr(3, 'h80);
    wr(0, 'h1B);  // enable, circular, both increments
    for (int i = 0; i < 4; i++) begin
      pulse_req();
      serve(1'b0, got, pa, ma);
      chk("R6 circular start", int'(got), 1);
      chk("R6 periph addr wraps", pa, 'h40 + (i % 2));
      chk("R6 mem addr wraps", ma, 'h80 + (i % 2));
      if (i == 1) begin
        rd(1, v); chk("R6 count reloaded", v, 2);
        rd(4, v); chk("R6 done on wrap", v, 1);
      end
    end
    rd(0, v); chk("R6 still enabled", v, 'h1B);
    wr(0, 0);  // abort: only the enable bit may change
    rd(0, v); chk("R10 abort keeps fields", v, 'h1A);
    pulse_req();
    no_start("R12 abort stops transfers", 6);
    wr(5, 3);
  endtask

  task automatic t_m2m();
    int v, pa, ma; bit got;
    wr(0, 0);
    wr(1, 3); wr(2, 'h10); wr(3, 'h20);
    wr(0, 'h1D);  // enable, memory-to-memory, both increments
    for (int i = 0; i < 3; i++) begin
      serve(1'b0, got, pa, ma);
      chk("R7 start without request", int'(got), 1);
      chk("R7 src addr", pa, 'h10 + i);
      chk("R7 dst addr", ma, 'h20 + i);
    end
    no_start("R7 stops at zero", 6);
    rd(4, v); chk("R7 done flag", v, 1);
    wr(5, 1);
    wr(0, 0);
  endtask

  task automatic t_error();
    int v, pa, ma; bit got;
    wr(0, 0);
    wr(1, 4); wr(2, 'h300); wr(3, 'h400);
    wr(0, 'h11);
    pulse_req();
    serve(1'b1, got, pa, ma);
    chk("R8 errored start seen", int'(got), 1);
    chk("R8 enable dropped", int'(chan_active), 0);
    chk("R8 error flag", int'(err_flag), 1);
    rd(0, v); chk("R8 ctrl after error", v, 'h10);
    wr(0, 'h11);
    rd(0, v); chk("R9 enable refused", v, 'h10);
    pulse_req();
    no_start("R9 no transfer while locked out", 6);
    wr(5, 2);
    rd(4, v); chk("R13 clear error", v, 0);
    wr(0, 'h11);
    rd(0, v); chk("R9 enable after clear", v, 'h11);
    pulse_req();
    serve(1'b0, got, pa, ma);
    chk("R9 transfer after re-enable", int'(got), 1);
    rd(1, v); chk("R9 count after resume", v, 3);
  endtask

  task automatic t_lock();
    int v;
    wr(0, 'h0F);
    rd(0, v); chk("R10 ctrl fields locked", v, 'h11);
    wr(1, 9);
    rd(1, v); chk("R10 count locked", v, 3);
    wr(2, 'h555);
    rd(2, v); chk("R10 paddr locked", v, 'h300);
    wr(0, 0);
  endtask

  task automatic t_circ_m2m();
    int v;
    wr(0, 'h07);
    rd(0, v); chk("R11 refused enable", v, 'h06);
    chk("R11 inactive", int'(chan_active), 0);
    pulse_req();
    no_start("R11 no transfer", 6);
    wr(0, 'h03);
    rd(0, v); chk("R11 circular alone enables", v, 'h03);
    wr(0, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_widx = '0; reg_wdata = '0; reg_ridx = '0;
    dma_req = 1'b0; xfer_ack = 1'b0; xfer_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_periph_normal();
    t_circular();
    t_m2m();
    t_error();
    t_lock();
    t_circ_m2m();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule